// File: doc/BRIEF.md
# Clock Failure Detector with Automatic Failover

This block supervises two clocks that come from outside the chip, using an always-running internal reference clock as its timebase. The first supervisor watches the fast external oscillator. Once that oscillator has reported ready and a start-up delay has run out, the supervisor expects a rising edge of the oscillator within every window of reference cycles. If no edge arrives in time, it acts on its own. It moves the system clock selection to the internal oscillator, but only when the external clock was in use, either directly or through the PLL. It drops the external oscillator enable. It drops the PLL enable when the PLL takes its input from the external oscillator. It also latches a failure flag, raises a non-maskable interrupt request, and sends a single-cycle break pulse to the timer blocks.

The second supervisor watches the slow low-power clock that feeds the real-time clock. Software can arm it only while that oscillator is on, is ready, and is selected as the real-time clock source. When it detects a failure, it sets a sticky flag. While the part is not in battery-backed mode, that flag also drives a wake-up request. This supervisor never disarms itself. The analog oscillators and the glitch-free clock switch sit outside this block, which produces only selection and enable signals. All software controls are synchronous to the reference clock. Each monitored clock is sampled through a synchronizer, so its frequency must stay below half the reference frequency.

Top module: `clk_fail_guard`

## Requirements
- R1: After reset, the following outputs are all low: failure flag, NMI request, break, fast-monitor-active, slow-armed, slow flag and wake. The enable and select outputs equal their software requests, and these are low in the reset state.
- R2: The fast monitor becomes active exactly START_CYC+1 reference cycles after the enable, oscillator-on and ready inputs are all high together. It goes inactive again when the monitor enable or the oscillator enable drops.
- R3: While the fast monitor is active and the monitored clock has a rising edge at least once per FAST_WIN reference cycles, no failure is declared.
- R4: When the fast monitor is active and no rising edge arrives for FAST_WIN reference cycles, `ffail_o` and `nmi_o` rise together. Both then stay high until a `ffail_clr_i` strobe.
- R5: Each fast failure produces exactly one reference cycle of `brk_o`, in the same cycle that `ffail_o` rises.
- R6: On a fast failure, `xosc_en_o` is forced low. It stays low until software takes `xosc_on_i` low. After that it follows `xosc_on_i` again.
- R7: On a fast failure, `pll_en_o` is forced low only if `pll_src_ext_i` is 1. It stays low until `pll_on_i` goes low. With `pll_src_ext_i` at 0, the PLL enable is left alone.
- R8: The system clock select uses the codes 00 internal, 01 external, 10 PLL and 11 other. On a fast failure, `sysclk_sel_o` becomes 00 only if the request was 01, or was 10 with `pll_src_ext_i` at 1. It is held at 00 until software requests 00. Any other selection passes through unchanged.
- R9: After a fast failure, the monitor does not re-arm while the ready input stays high, even if the oscillator is switched off and on again. It re-arms only after ready drops, then rises, and then a full start-up delay completes.
- R10: A slow-monitor arm strobe takes effect only if `lp_on_i`, `lp_rdy_i` and `rtc_sel_lp_i` are all 1. Otherwise it is ignored and `smon_armed_o` stays low.
- R11: An armed slow monitor that sees no rising edge for SLOW_WIN reference cycles sets `sfail_o`. The monitor stays armed. The flag clears only on `sfail_clr_i`, and the monitor disarms only on `smon_disarm_i`.
- R12: `wake_o` is high while `sfail_o` is high and `lp_vbat_i` is low. In battery-backed mode it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal reference clock, always running |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xosc_clk_i | input | 1 | Fast external oscillator clock under watch |
| lp_clk_i | input | 1 | Slow low-power clock under watch |
| fmon_en_i | input | 1 | Software enable of the fast monitor |
| xosc_on_i | input | 1 | Software request to run the external oscillator |
| xosc_rdy_i | input | 1 | External oscillator ready indication |
| sysclk_sel_i | input | 2 | Requested system clock source (00 int, 01 ext, 10 PLL, 11 other) |
| pll_on_i | input | 1 | Software request to run the PLL |
| pll_src_ext_i | input | 1 | PLL input taken from the external oscillator |
| ffail_clr_i | input | 1 | Clear strobe for the fast failure flag and NMI |
| xosc_en_o | output | 1 | External oscillator enable after failover |
| pll_en_o | output | 1 | PLL enable after failover |
| sysclk_sel_o | output | 2 | System clock select after failover |
| ffail_o | output | 1 | Latched fast-clock failure flag |
| nmi_o | output | 1 | Non-maskable interrupt request |
| brk_o | output | 1 | Single-cycle break event to the timers |
| fmon_active_o | output | 1 | Fast monitor is watching edges |
| smon_arm_i | input | 1 | Arm strobe for the slow monitor |
| smon_disarm_i | input | 1 | Disarm strobe for the slow monitor |
| lp_on_i | input | 1 | Slow oscillator enabled |
| lp_rdy_i | input | 1 | Slow oscillator ready |
| rtc_sel_lp_i | input | 1 | Slow oscillator selected as real-time clock source |
| lp_vbat_i | input | 1 | Part in battery-backed mode |
| sfail_clr_i | input | 1 | Clear strobe for the slow failure flag |
| smon_armed_o | output | 1 | Slow monitor armed |
| sfail_o | output | 1 | Sticky slow-clock failure flag |
| wake_o | output | 1 | Wake-up request from a slow-clock failure |

## Verification
The bench aims at the start-up boundary. It samples the active indication one cycle before the delay ends and again just after. A design that watches edges before the oscillator settles would declare false failures on every cold start. The bench runs three failover cases that differ in the clock selection and the PLL source. These separate a design that always drops the PLL, or always forces the internal clock, from one that acts only when the external clock was really in use. The bench probes re-arming after a failure with the ready line still high; a design that re-arms on the oscillator toggle alone would trip again at once on a dead crystal. On the slow side, the bench tries each missing arming precondition, checks that the flag survives until its clear strobe, and checks that battery mode masks the wake request.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

   typedef enum logic [1:0] {
      SEL_INT = 2'b00,
      SEL_EXT = 2'b01,
      SEL_PLL = 2'b10,
      SEL_AUX = 2'b11
   } sysclk_e;

   typedef enum logic [1:0] {
      FG_OFF   = 2'b00,
      FG_WARM  = 2'b01,
      FG_WATCH = 2'b10,
      FG_TRIP  = 2'b11
   } fguard_e;

   // True when the requested system clock depends on the external oscillator.
   function automatic logic sel_uses_ext(input logic [1:0] sel, input logic pll_ext);
      return (sel == SEL_EXT) || ((sel == SEL_PLL) && pll_ext);
   endfunction

endpackage

// File: rtl/edge_watch.sv
// Synchronizes a foreign clock into the reference domain and flags a window
// of WIN reference cycles that passes without a rising edge.
module edge_watch #(
   parameter int WIN  = 16,
   parameter int SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mon_clk,
   input  logic en,
   output logic tout
);
   localparam int CW = $clog2(WIN);

   if (WIN < 4) begin : g_bad_win
      $error("edge_watch: WIN must be at least 4");
   end
   if (SYNC < 2) begin : g_bad_sync
      $error("edge_watch: SYNC must be at least 2");
   end

   logic [SYNC-1:0] sync_q;
   logic            last_q;
   logic            rise;
   logic [CW-1:0]   cnt_q;
   logic            at_end;

   for (genvar i = 0; i < SYNC; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= mon_clk;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[SYNC-1];
   end

   assign rise   = sync_q[SYNC-1] & ~last_q;
   assign at_end = (cnt_q == CW'(WIN - 1));
   assign tout   = en & ~rise & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!en || rise)    cnt_q <= '0;
      else if (at_end)         cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/fast_guard.sv
// Fast-oscillator supervisor: start-up qualification, edge watch, failover.
module fast_guard
   import cfg_guard_pkg::*;
#(
   parameter int START = 64,
   parameter int WIN   = 16,
   parameter int SYNC  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mon_clk,
   input  logic       mon_en,
   input  logic       osc_on,
   input  logic       osc_rdy,
   input  logic [1:0] sel_req,
   input  logic       pll_on,
   input  logic       pll_ext,
   input  logic       clr,
   output logic       osc_en,
   output logic       pll_en,
   output logic [1:0] sel_out,
   output logic       flag,
   output logic       brk,
   output logic       active
);
   localparam int SCW = (START > 1) ? $clog2(START) : 1;

   if (START < 2) begin : g_bad_start
      $error("fast_guard: START must be at least 2");
   end

   fguard_e        st_q, st_d;
   logic [SCW-1:0] wcnt_q;
   logic           tout;
   logic           fail;
   logic           kill_osc_q, kill_pll_q, kill_sel_q;
   logic           flag_q, brk_q;
   logic           qual;

   edge_watch #(.WIN(WIN), .SYNC(SYNC)) u_watch (
      .clk     (clk),
      .rst_n   (rst_n),
      .mon_clk (mon_clk),
      .en      (st_q == FG_WATCH),
      .tout    (tout)
   );

   assign osc_en = osc_on & ~kill_osc_q;
   assign pll_en = pll_on & ~kill_pll_q;
   assign sel_out = kill_sel_q ? SEL_INT : sel_req;
   assign qual   = mon_en & osc_en & osc_rdy;
   assign fail   = (st_q == FG_WATCH) & tout & mon_en & osc_en;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         FG_OFF:   if (qual) st_d = FG_WARM;
         FG_WARM:  if (!qual) st_d = FG_OFF;
                   else if (wcnt_q == SCW'(START - 1)) st_d = FG_WATCH;
         FG_WATCH: if (!mon_en || !osc_en) st_d = FG_OFF;
                   else if (fail) st_d = FG_TRIP;
         FG_TRIP:  if (!osc_rdy) st_d = FG_OFF;
         default:  st_d = FG_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= FG_OFF;
         wcnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == FG_WARM && st_d == FG_WARM) wcnt_q <= wcnt_q + 1'b1;
         else                                   wcnt_q <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kill_osc_q <= 1'b0;
         kill_pll_q <= 1'b0;
         kill_sel_q <= 1'b0;
         flag_q     <= 1'b0;
         brk_q      <= 1'b0;
      end else begin
         brk_q <= fail;
         if (fail)         kill_osc_q <= 1'b1;
         else if (!osc_on) kill_osc_q <= 1'b0;
         if (fail && pll_ext) kill_pll_q <= 1'b1;
         else if (!pll_on)    kill_pll_q <= 1'b0;
         if (fail && sel_uses_ext(sel_req, pll_ext)) kill_sel_q <= 1'b1;
         else if (sel_req == SEL_INT)                kill_sel_q <= 1'b0;
         if (fail)     flag_q <= 1'b1;
         else if (clr) flag_q <= 1'b0;
      end
   end

   assign flag   = flag_q;
   assign brk    = brk_q;
   assign active = (st_q == FG_WATCH);

endmodule

// File: rtl/slow_guard.sv
// Slow-clock supervisor: gated arming, sticky failure flag, wake request.
module slow_guard #(
   parameter int WIN  = 32,
   parameter int SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mon_clk,
   input  logic arm_req,
   input  logic disarm_req,
   input  logic osc_on,
   input  logic osc_rdy,
   input  logic rtc_sel,
   input  logic vbat,
   input  logic clr,
   output logic armed,
   output logic flag,
   output logic wake
);
   logic armed_q, flag_q, tout;

   edge_watch #(.WIN(WIN), .SYNC(SYNC)) u_watch (
      .clk     (clk),
      .rst_n   (rst_n),
      .mon_clk (mon_clk),
      .en      (armed_q),
      .tout    (tout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         if (disarm_req) armed_q <= 1'b0;
         else if (arm_req && osc_on && osc_rdy && rtc_sel) armed_q <= 1'b1;
         if (armed_q && tout) flag_q <= 1'b1;
         else if (clr)        flag_q <= 1'b0;
      end
   end

   assign armed = armed_q;
   assign flag  = flag_q;
   assign wake  = flag_q & ~vbat;

endmodule

// File: rtl/clk_fail_guard.sv
module clk_fail_guard #(
   parameter int FAST_WIN    = 16,
   parameter int SLOW_WIN    = 32,
   parameter int START_CYC   = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       xosc_clk_i,
   input  logic       lp_clk_i,
   input  logic       fmon_en_i,
   input  logic       xosc_on_i,
   input  logic       xosc_rdy_i,
   input  logic [1:0] sysclk_sel_i,
   input  logic       pll_on_i,
   input  logic       pll_src_ext_i,
   input  logic       ffail_clr_i,
   output logic       xosc_en_o,
   output logic       pll_en_o,
   output logic [1:0] sysclk_sel_o,
   output logic       ffail_o,
   output logic       nmi_o,
   output logic       brk_o,
   output logic       fmon_active_o,
   input  logic       smon_arm_i,
   input  logic       smon_disarm_i,
   input  logic       lp_on_i,
   input  logic       lp_rdy_i,
   input  logic       rtc_sel_lp_i,
   input  logic       lp_vbat_i,
   input  logic       sfail_clr_i,
   output logic       smon_armed_o,
   output logic       sfail_o,
   output logic       wake_o
);
   logic fflag;

   fast_guard #(.START(START_CYC), .WIN(FAST_WIN), .SYNC(SYNC_STAGES)) u_fast (
      .clk     (clk_i),
      .rst_n   (rst_ni),
      .mon_clk (xosc_clk_i),
      .mon_en  (fmon_en_i),
      .osc_on  (xosc_on_i),
      .osc_rdy (xosc_rdy_i),
      .sel_req (sysclk_sel_i),
      .pll_on  (pll_on_i),
      .pll_ext (pll_src_ext_i),
      .clr     (ffail_clr_i),
      .osc_en  (xosc_en_o),
      .pll_en  (pll_en_o),
      .sel_out (sysclk_sel_o),
      .flag    (fflag),
      .brk     (brk_o),
      .active  (fmon_active_o)
   );

   assign ffail_o = fflag;
   assign nmi_o   = fflag;

   slow_guard #(.WIN(SLOW_WIN), .SYNC(SYNC_STAGES)) u_slow (
      .clk        (clk_i),
      .rst_n      (rst_ni),
      .mon_clk    (lp_clk_i),
      .arm_req    (smon_arm_i),
      .disarm_req (smon_disarm_i),
      .osc_on     (lp_on_i),
      .osc_rdy    (lp_rdy_i),
      .rtc_sel    (rtc_sel_lp_i),
      .vbat       (lp_vbat_i),
      .clr        (sfail_clr_i),
      .armed      (smon_armed_o),
      .flag       (sfail_o),
      .wake       (wake_o)
   );

endmodule

// File: rtl/clk_fail_guard_chk.sv
module clk_fail_guard_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [1:0] sysclk_sel_i,
   input logic       pll_on_i,
   input logic       pll_src_ext_i,
   input logic       ffail_clr_i,
   input logic       xosc_en_o,
   input logic       pll_en_o,
   input logic [1:0] sysclk_sel_o,
   input logic       ffail_o,
   input logic       brk_o,
   input logic       fmon_active_o,
   input logic       lp_on_i,
   input logic       lp_rdy_i,
   input logic       rtc_sel_lp_i,
   input logic       lp_vbat_i,
   input logic       sfail_clr_i,
   input logic       smon_armed_o,
   input logic       sfail_o,
   input logic       wake_o
);
   AST_FFLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ffail_o && !ffail_clr_i |=> ffail_o); // R4
   AST_BRK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_o |=> !brk_o); // R5
   AST_BRK_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_o |-> $rose(ffail_o)); // R5
   AST_TRIP_STOPS_WATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ffail_o) |-> !fmon_active_o); // R9
   AST_XOSC_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ffail_o) |-> !xosc_en_o); // R6
   AST_PLL_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ffail_o) && !$past(pll_src_ext_i) && $past(pll_en_o) && pll_on_i |-> pll_en_o); // R7
   AST_SEL_FALLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ffail_o) && ($past(sysclk_sel_i) == 2'b01 ||
      ($past(sysclk_sel_i) == 2'b10 && $past(pll_src_ext_i))) |-> sysclk_sel_o == 2'b00); // R8
   AST_ARM_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(smon_armed_o) |-> $past(lp_on_i && lp_rdy_i && rtc_sel_lp_i)); // R10
   AST_SFLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sfail_o && !sfail_clr_i |=> sfail_o); // R11
   AST_WAKE_VBAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lp_vbat_i |-> !wake_o); // R12
endmodule

bind clk_fail_guard clk_fail_guard_chk u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .sysclk_sel_i  (sysclk_sel_i),
   .pll_on_i      (pll_on_i),
   .pll_src_ext_i (pll_src_ext_i),
   .ffail_clr_i   (ffail_clr_i),
   .xosc_en_o     (xosc_en_o),
   .pll_en_o      (pll_en_o),
   .sysclk_sel_o  (sysclk_sel_o),
   .ffail_o       (ffail_o),
   .brk_o         (brk_o),
   .fmon_active_o (fmon_active_o),
   .lp_on_i       (lp_on_i),
   .lp_rdy_i      (lp_rdy_i),
   .rtc_sel_lp_i  (rtc_sel_lp_i),
   .lp_vbat_i     (lp_vbat_i),
   .sfail_clr_i   (sfail_clr_i),
   .smon_armed_o  (smon_armed_o),
   .sfail_o       (sfail_o),
   .wake_o        (wake_o)
);

// File: tb/clk_fail_guard_tb.sv
`timescale 1ns/1ps
module clk_fail_guard_tb;
   localparam int FWIN  = 16;
   localparam int SWIN  = 32;
   localparam int START = 64;

   logic clk = 1'b0, rst_n = 1'b0;
   logic xclk = 1'b0, lclk = 1'b0, xrun = 1'b0, lrun = 1'b0;
   logic fmon_en = 0, xosc_on = 0, xrdy = 0, pll_on = 0, pll_ext = 0, fclr = 0;
   logic [1:0] sel_req = 2'b00;
   logic arm = 0, disarm = 0, lp_on = 0, lp_rdy = 0, rtc_sel = 0, vbat = 0, sclr = 0;
   logic xosc_en, pll_en, ffail, nmi, brk, factive, armed, sfail, wake;
   logic [1:0] sel_out;

   int vectors = 0, miscompares = 0, brk_cnt = 0;
   bit done = 0;

   always #4 clk = ~clk;
   always begin #20; if (xrun) xclk = ~xclk; end
   always begin #48; if (lrun) lclk = ~lclk; end
   always @(negedge clk) if (brk) brk_cnt++;

   clk_fail_guard #(.FAST_WIN(FWIN), .SLOW_WIN(SWIN), .START_CYC(START)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .xosc_clk_i(xclk), .lp_clk_i(lclk),
      .fmon_en_i(fmon_en), .xosc_on_i(xosc_on), .xosc_rdy_i(xrdy),
      .sysclk_sel_i(sel_req), .pll_on_i(pll_on), .pll_src_ext_i(pll_ext),
      .ffail_clr_i(fclr), .xosc_en_o(xosc_en), .pll_en_o(pll_en),
      .sysclk_sel_o(sel_out), .ffail_o(ffail), .nmi_o(nmi), .brk_o(brk),
      .fmon_active_o(factive), .smon_arm_i(arm), .smon_disarm_i(disarm),
      .lp_on_i(lp_on), .lp_rdy_i(lp_rdy), .rtc_sel_lp_i(rtc_sel),
      .lp_vbat_i(vbat), .sfail_clr_i(sclr), .smon_armed_o(armed),
      .sfail_o(sfail), .wake_o(wake));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic t_reset;
      chk("R1 ffail", ffail, 0);   chk("R1 nmi", nmi, 0);     chk("R1 brk", brk, 0);
      chk("R1 active", factive, 0); chk("R1 armed", armed, 0); chk("R1 sfail", sfail, 0);
      chk("R1 wake", wake, 0);     chk("R1 xosc_en", xosc_en, 0);
      chk("R1 pll_en", pll_en, 0); chk("R1 sel", sel_out, 0);
   endtask

   task automatic t_bringup(input logic [1:0] sel, input logic ext);
      sel_req = sel; pll_on = 1; pll_ext = ext;
      xosc_on = 1; xrun = 1; fmon_en = 1; xrdy = 1;
      tick(START - 1);
      chk("R2 not yet active", factive, 0);
      tick(4);
      chk("R2 active after delay", factive, 1);
      tick(100);
      chk("R3 no false failure", ffail, 0);
      chk("R3 xosc enabled", xosc_en, 1);
      chk("R7 pll enabled", pll_en, 1);
      chk("R8 sel passes", sel_out, sel);
   endtask

   task automatic t_trip(input logic [1:0] exp_sel, input logic exp_pll);
      int b0 = brk_cnt;
      xrun = 0;
      tick(8);
      chk("R4 no early failure", ffail, 0);
      tick(FWIN + 12);
      chk("R4 flag set", ffail, 1);
      chk("R4 nmi set", nmi, 1);
      chk("R5 one break cycle", brk_cnt - b0, 1);
      chk("R6 xosc dropped", xosc_en, 0);
      chk("R7 pll enable", pll_en, exp_pll);
      chk("R8 sel fallback", sel_out, exp_sel);
      chk("R9 watch stopped", factive, 0);
      tick(20);
      chk("R4 flag held", ffail, 1);
      chk("R6 xosc still off", xosc_en, 0);
      fclr = 1; tick(1); fclr = 0;
      chk("R4 flag cleared", ffail, 0);
      chk("R4 nmi cleared", nmi, 0);
   endtask

   task automatic t_recover;
      xosc_on = 0; sel_req = 2'b00; pll_on = 0;
      tick(2);
      chk("R8 sel internal", sel_out, 0);
      xosc_on = 1; xrun = 1;
      tick(1);
      chk("R6 xosc reenabled", xosc_en, 1);
      tick(START + 20);
      chk("R9 no rearm without new ready", factive, 0);
      xrdy = 0; tick(2); xrdy = 1;
      tick(START + 3);
      chk("R9 rearmed after new ready", factive, 1);
      fmon_en = 0; tick(2);
      chk("R2 inactive when disabled", factive, 0);
      xosc_on = 0; xrdy = 0; tick(2);
   endtask

   task automatic t_slow;
      lrun = 1; lp_on = 1; lp_rdy = 0; rtc_sel = 1;
      arm = 1; tick(1); arm = 0;
      chk("R10 arm ignored not ready", armed, 0);
      lp_rdy = 1; rtc_sel = 0;
      arm = 1; tick(1); arm = 0;
      chk("R10 arm ignored not selected", armed, 0);
      rtc_sel = 1; lp_on = 0;
      arm = 1; tick(1); arm = 0;
      chk("R10 arm ignored osc off", armed, 0);
      lp_on = 1;
      arm = 1; tick(1); arm = 0;
      chk("R10 armed", armed, 1);
      tick(100);
      chk("R11 no false failure", sfail, 0);
      lrun = 0;
      tick(SWIN + 20);
      chk("R11 flag set", sfail, 1);
      chk("R11 still armed", armed, 1);
      chk("R12 wake", wake, 1);
      vbat = 1; tick(1);
      chk("R12 wake masked in battery mode", wake, 0);
      chk("R11 flag kept", sfail, 1);
      vbat = 0; tick(1);
      chk("R12 wake back", wake, 1);
      lrun = 1; tick(30);
      chk("R11 flag survives clock return", sfail, 1);
      sclr = 1; tick(1); sclr = 0;
      tick(60);
      chk("R11 flag cleared", sfail, 0);
      chk("R11 armed after clear", armed, 1);
      disarm = 1; tick(1); disarm = 0;
      chk("R11 disarmed", armed, 0);
      lrun = 0; tick(SWIN + 30);
      chk("R11 disarmed raises nothing", sfail, 0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1;
      tick(1);
      t_reset();
      t_bringup(2'b10, 1'b1); t_trip(2'b00, 1'b0); t_recover();
      t_bringup(2'b01, 1'b0); t_trip(2'b00, 1'b1); t_recover();
      t_bringup(2'b10, 1'b0); t_trip(2'b10, 1'b1); t_recover();
      t_slow();
      finish_run();
   end
endmodule